// File: doc/BRIEF.md
# Debug Segment Access Router

This block sits between a 32-bit processor's load/store unit and the destinations a data access can reach. Each cycle it captures one request in a register. The request carries a virtual address, a direction, a size code, the debug-mode state and three control bits. From that registered request it decides, combinationally, which single target receives the access. The targets are the normal memory path, the external debug probe port, the on-core debug register bank, and the trace unit's register slice.

The debug segment spans 0xFF200000–0xFF3FFFFF. Its lower megabyte (0xFF200000–0xFF2FFFFF) is the probe-memory window, and that window holds the debug entry vector at 0xFF200200. Its upper megabyte (0xFF300000–0xFF3FFFFF) is the debug-register window, which contains the trace slice 0xFF301000–0xFF301FFF.

The segment is treated as a separate region only in debug mode, and only while the pass-through control bit is clear. The probe window needs a probe that is both present and enabled. The register window serves aligned full-word accesses only; anything else raises an address error instead of a select. Accesses in the first sixteen bytes of the probe window are flagged, so the probe port can use its block transfer mode.

Top module: `dseg_router`

## Requirements
- R1: All outputs are decoded from the request registered at the previous rising clock edge. While reset is high, and for any request with `req_valid` low, every select, `addr_err`, `probe_fast` and `out_write` is 0. For a valid request, `out_write` repeats `req_write`.
- R2: When `dbg_mode` is 0, every valid access selects memory. When `dbg_mode` is 1, any address outside 0xFF200000–0xFF3FFFFF also selects memory.
- R3: In debug mode with `dseg_passthru` set to 1, every valid access to 0xFF200000–0xFF3FFFFF selects memory, whatever its size or alignment.
- R4: In debug mode with pass-through clear, an access to 0xFF200000–0xFF2FFFFF selects the probe when `probe_present` and `probe_enable` are both 1.
- R5: Under the conditions of R4, if either `probe_present` or `probe_enable` is 0, the access selects memory instead.
- R6: In debug mode with pass-through clear, an access to 0xFF300000–0xFF3FFFFF that lies outside the trace slice selects the debug register bank. The access must be word-sized (`req_size` = 2) with address bits [1:0] = 00.
- R7: An access meeting R6's conditions but inside 0xFF301000–0xFF301FFF selects the trace unit instead of the register bank.
- R8: In debug mode with pass-through clear, an access to 0xFF300000–0xFF3FFFFF is rejected in either of two cases: `req_size` is 0 (byte), 1 (half) or 3 (reserved), or address bits [1:0] are not 00. A rejected access raises `addr_err` and asserts no select.
- R9: `probe_fast` is 1 exactly when the probe is selected and the address lies in 0xFF200000–0xFF20000F.
- R10: The entry vector 0xFF200200 routes to the probe under the conditions of R4, and it does not raise `probe_fast`.
- R11: For every valid request, exactly one of `sel_mem`, `sel_probe`, `sel_dreg`, `sel_trace` and `addr_err` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Virtual data address |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 reserved |
| dbg_mode | input | 1 | Core is in debug mode |
| dseg_passthru | input | 1 | Route debug-segment data accesses to the kernel memory beneath |
| probe_present | input | 1 | A probe is attached and active |
| probe_enable | input | 1 | Probe servicing of its window is enabled |
| sel_mem | output | 1 | Select normal memory path |
| sel_probe | output | 1 | Select debug probe port |
| sel_dreg | output | 1 | Select debug register bank |
| sel_trace | output | 1 | Select trace unit registers |
| addr_err | output | 1 | Rejected access to the register window |
| probe_fast | output | 1 | Probe access lies in the block-transfer range |
| out_write | output | 1 | Direction of the routed access |

## Verification
Directed cases sit on each window edge: 0xFF1FFFFC and 0xFF400000 against the segment ends, 0xFF20000F against 0xFF200010, and 0xFF300FFC, 0xFF301000, 0xFF301FFC and 0xFF302000 around the trace slice. Together they separate an off-by-one range compare from a correct one. Toggling `dbg_mode`, `dseg_passthru`, `probe_present` and `probe_enable` one at a time on a fixed address shows that each control bit gates only its own path. Byte, half, reserved and misaligned word accesses to the register window tell rejection apart from routing. Seeded random requests, weighted towards the windows, then cover the mixed combinations against a reference function.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    localparam int AW = 32;

    typedef logic [AW-1:0] addr_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // Registered request
    typedef struct packed {
        logic  valid;
        addr_t addr;
        logic  write;
        size_e size;
        logic  dbg;
        logic  passthru;
        logic  probe_ok;
    } req_t;

    // Address classification
    typedef struct packed {
        logic dseg;
        logic probe_win;
        logic reg_win;
        logic trace_win;
        logic fast_win;
    } region_t;

    // Routing decision
    typedef struct packed {
        logic mem;
        logic probe;
        logic dreg;
        logic trace;
        logic err;
        logic fast;
    } route_t;

    // True when a lies in the 2**lg2 byte block that starts at base
    function automatic logic in_window(addr_t a, addr_t base, int unsigned lg2);
        addr_t keep;
        keep = ~((addr_t'(1) << lg2) - addr_t'(1));
        return (a & keep) == (base & keep);
    endfunction

    function automatic logic full_word(size_e s, logic [1:0] lo);
        return (s == SZ_WORD) && (lo == 2'b00);
    endfunction

endpackage

// File: rtl/dsr_req_reg.sv
module dsr_req_reg
    import dsr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t d,
    output req_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/dsr_decode.sv
module dsr_decode
    import dsr_pkg::*;
#(
    parameter logic [31:0] DSEG_BASE = 32'hFF20_0000,
    parameter int unsigned WIN_LG2   = 20,
    parameter logic [31:0] TRACE_OFF = 32'h0000_1000,
    parameter int unsigned TRACE_LG2 = 12,
    parameter int unsigned FAST_LG2  = 4
) (
    input  addr_t   addr,
    output region_t reg_o
);
    localparam addr_t PROBE_BASE = DSEG_BASE;
    localparam addr_t DREG_BASE  = DSEG_BASE + (addr_t'(1) << WIN_LG2);
    localparam addr_t TRACE_BASE = DREG_BASE + TRACE_OFF;
    localparam int unsigned DSEG_LG2 = WIN_LG2 + 1;

    always_comb begin
        reg_o.dseg      = in_window(addr, DSEG_BASE, DSEG_LG2);
        reg_o.probe_win = in_window(addr, PROBE_BASE, WIN_LG2);
        reg_o.reg_win   = in_window(addr, DREG_BASE, WIN_LG2);
        reg_o.trace_win = in_window(addr, TRACE_BASE, TRACE_LG2);
        reg_o.fast_win  = in_window(addr, PROBE_BASE, FAST_LG2);
    end
endmodule

// File: rtl/dsr_route.sv
module dsr_route
    import dsr_pkg::*;
(
    input  req_t    q,
    input  region_t g,
    output route_t  r
);
    always_comb begin
        r = '0;
        if (q.valid) begin
            if (!q.dbg || q.passthru || !g.dseg) begin
                r.mem = 1'b1;
            end else if (g.probe_win) begin
                if (q.probe_ok) begin
                    r.probe = 1'b1;
                    r.fast  = g.fast_win;
                end else begin
                    r.mem = 1'b1;
                end
            end else if (!full_word(q.size, q.addr[1:0])) begin
                r.err = 1'b1;
            end else if (g.trace_win) begin
                r.trace = 1'b1;
            end else begin
                r.dreg = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dseg_router.sv
module dseg_router
    import dsr_pkg::*;
#(
    parameter logic [31:0] DSEG_BASE = 32'hFF20_0000,
    parameter int unsigned WIN_LG2   = 20,
    parameter logic [31:0] TRACE_OFF = 32'h0000_1000,
    parameter int unsigned TRACE_LG2 = 12,
    parameter int unsigned FAST_LG2  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic [1:0]  req_size,
    input  logic        dbg_mode,
    input  logic        dseg_passthru,
    input  logic        probe_present,
    input  logic        probe_enable,
    output logic        sel_mem,
    output logic        sel_probe,
    output logic        sel_dreg,
    output logic        sel_trace,
    output logic        addr_err,
    output logic        probe_fast,
    output logic        out_write
);
    req_t    req_d;
    req_t    req_q;
    region_t region;
    route_t  route;

    always_comb begin
        req_d.valid    = req_valid;
        req_d.addr     = req_addr;
        req_d.write    = req_write;
        req_d.size     = size_e'(req_size);
        req_d.dbg      = dbg_mode;
        req_d.passthru = dseg_passthru;
        req_d.probe_ok = probe_present & probe_enable;
    end

    dsr_req_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (req_d),
        .q   (req_q)
    );

    dsr_decode #(
        .DSEG_BASE (DSEG_BASE),
        .WIN_LG2   (WIN_LG2),
        .TRACE_OFF (TRACE_OFF),
        .TRACE_LG2 (TRACE_LG2),
        .FAST_LG2  (FAST_LG2)
    ) u_dec (
        .addr  (req_q.addr),
        .reg_o (region)
    );

    dsr_route u_route (
        .q (req_q),
        .g (region),
        .r (route)
    );

    assign sel_mem    = route.mem;
    assign sel_probe  = route.probe;
    assign sel_dreg   = route.dreg;
    assign sel_trace  = route.trace;
    assign addr_err   = route.err;
    assign probe_fast = route.fast;
    assign out_write  = req_q.valid & req_q.write;
endmodule

// File: rtl/dseg_router_chk.sv
module dseg_router_chk #(
    parameter logic [31:0] DSEG_BASE = 32'hFF20_0000,
    parameter int unsigned WIN_LG2   = 20
) (
    input logic        clk,
    input logic        rst,
    input logic        q_valid,
    input logic [31:0] q_addr,
    input logic [1:0]  q_size,
    input logic        q_dbg,
    input logic        q_passthru,
    input logic        sel_mem,
    input logic        sel_probe,
    input logic        sel_dreg,
    input logic        sel_trace,
    input logic        addr_err,
    input logic        probe_fast
);
    localparam logic [31:0] REG_TAG = (DSEG_BASE >> WIN_LG2) + 32'd1;

    logic in_reg_win;
    assign in_reg_win = ((q_addr >> WIN_LG2) == REG_TAG);

    // R11: one outcome per valid request
    p_one_target_r11: assert property (@(posedge clk) disable iff (rst)
        q_valid |-> $countones({sel_mem, sel_probe, sel_dreg, sel_trace, addr_err}) == 1);

    // R1: idle request drives nothing
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !q_valid |-> !(sel_mem | sel_probe | sel_dreg | sel_trace | addr_err | probe_fast));

    // R2: outside debug mode everything goes to memory
    p_normal_mode_r2: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_dbg) |-> sel_mem);

    // R3: pass-through forces memory
    p_passthru_r3: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_passthru) |-> sel_mem);

    // R6: register window never reaches the probe
    p_reg_win_no_probe_r6: assert property (@(posedge clk) disable iff (rst)
        in_reg_win |-> !sel_probe);

    // R8: on-core register selects only for aligned words
    p_word_only_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_dreg || sel_trace) |-> (q_size == 2'd2 && q_addr[1:0] == 2'b00));

    // R9: fast flag only accompanies a probe select
    p_fast_with_probe_r9: assert property (@(posedge clk) disable iff (rst)
        probe_fast |-> sel_probe);
endmodule

bind dseg_router dseg_router_chk #(
    .DSEG_BASE (DSEG_BASE),
    .WIN_LG2   (WIN_LG2)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .q_valid    (req_q.valid),
    .q_addr     (req_q.addr),
    .q_size     (req_q.size),
    .q_dbg      (req_q.dbg),
    .q_passthru (req_q.passthru),
    .sel_mem    (sel_mem),
    .sel_probe  (sel_probe),
    .sel_dreg   (sel_dreg),
    .sel_trace  (sel_trace),
    .addr_err   (addr_err),
    .probe_fast (probe_fast)
);

// File: tb/dseg_router_bench.sv
`timescale 1ns/1ps
module dseg_router_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd2;
    logic        dbg_mode = 1'b0;
    logic        dseg_passthru = 1'b0;
    logic        probe_present = 1'b0;
    logic        probe_enable = 1'b0;
    logic        sel_mem, sel_probe, sel_dreg, sel_trace, addr_err, probe_fast, out_write;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dseg_router u_dseg_router (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_size      (req_size),
        .dbg_mode      (dbg_mode),
        .dseg_passthru (dseg_passthru),
        .probe_present (probe_present),
        .probe_enable  (probe_enable),
        .sel_mem       (sel_mem),
        .sel_probe     (sel_probe),
        .sel_dreg      (sel_dreg),
        .sel_trace     (sel_trace),
        .addr_err      (addr_err),
        .probe_fast    (probe_fast),
        .out_write     (out_write)
    );

    // Expected {mem, probe, dreg, trace, err, fast, write}
    function automatic logic [6:0] model(logic [31:0] a, logic w, logic [1:0] sz,
                                         logic dbg, logic byp, logic pres, logic en,
                                         logic v, output string tag);
        logic [6:0] e;
        e = '0;
        tag = "R1";
        if (!v) return e;
        e[0] = w;
        if (!dbg || a < 32'hFF20_0000 || a > 32'hFF3F_FFFF) begin
            e[6] = 1'b1; tag = "R2";
        end else if (byp) begin
            e[6] = 1'b1; tag = "R3";
        end else if (a <= 32'hFF2F_FFFF) begin
            if (pres && en) begin
                e[5] = 1'b1;
                e[1] = (a <= 32'hFF20_000F);
                tag = (a == 32'hFF20_0200) ? "R10" : (e[1] ? "R9" : "R4");
            end else begin
                e[6] = 1'b1; tag = "R5";
            end
        end else if (sz != 2'd2 || a[1:0] != 2'b00) begin
            e[2] = 1'b1; tag = "R8";
        end else if (a >= 32'hFF30_1000 && a <= 32'hFF30_1FFF) begin
            e[3] = 1'b1; tag = "R7";
        end else begin
            e[4] = 1'b1; tag = "R6";
        end
        return e;
    endfunction

    function automatic logic [6:0] actual();
        return {sel_mem, sel_probe, sel_dreg, sel_trace, addr_err, probe_fast, out_write};
    endfunction

    task automatic check_vec(string tag, logic [6:0] exp);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s: addr=%h got=%b expected=%b", tag, req_addr, actual(), exp);
        end
    endtask

    // Drive one request, then sample after the capturing edge
    task automatic apply(logic [31:0] a, logic w, logic [1:0] sz, logic dbg, logic byp,
                         logic pres, logic en, logic v, string note);
        string tag;
        logic [6:0] exp;
        @(negedge clk);
        req_addr = a; req_write = w; req_size = sz; dbg_mode = dbg;
        dseg_passthru = byp; probe_present = pres; probe_enable = en; req_valid = v;
        exp = model(a, w, sz, dbg, byp, pres, en, v, tag);
        @(posedge clk);
        #1;
        if (note != "") tag = note;
        check_vec(tag, exp);
        if (v) begin
            checks++;
            if ($countones(actual() >> 2) != 1) begin
                errors++;
                $display("FAIL R11: outcome bits=%b expected exactly one set", actual() >> 2);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset holds outputs low even with a valid request at the inputs
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'hFF20_0000; dbg_mode = 1'b1;
        probe_present = 1'b1; probe_enable = 1'b1; req_write = 1'b1;
        @(posedge clk); #1;
        check_vec("R1", 7'b0);
        @(negedge clk); rst = 1'b0;

        apply(32'hFF20_0000, 1, 2, 1, 0, 1, 1, 0, "R1");  // idle
        apply(32'hFF20_0000, 0, 2, 0, 0, 1, 1, 1, "R2");
        apply(32'h8000_1000, 0, 2, 1, 0, 1, 1, 1, "R2");
        apply(32'hFF1F_FFFC, 0, 2, 1, 0, 1, 1, 1, "R2");
        apply(32'hFF40_0000, 0, 2, 1, 0, 1, 1, 1, "R2");
        apply(32'hFF30_0000, 0, 2, 1, 1, 1, 1, 1, "R3");
        apply(32'hFF30_0001, 0, 0, 1, 1, 1, 1, 1, "R3");
        apply(32'hFF2A_BC00, 0, 2, 1, 0, 1, 1, 1, "R4");
        apply(32'hFF2F_FFFC, 1, 2, 1, 0, 1, 1, 1, "R4");
        apply(32'hFF2A_BC00, 0, 2, 1, 0, 0, 1, 1, "R5");
        apply(32'hFF2A_BC00, 0, 2, 1, 0, 1, 0, 1, "R5");
        apply(32'hFF20_0200, 0, 2, 1, 0, 1, 1, 1, "R10");
        apply(32'hFF20_000C, 0, 2, 1, 0, 1, 1, 1, "R9");
        apply(32'hFF20_000F, 0, 0, 1, 0, 1, 1, 1, "R9");
        apply(32'hFF20_0010, 0, 2, 1, 0, 1, 1, 1, "R9");
        apply(32'hFF20_0004, 0, 2, 1, 0, 0, 1, 1, "R9");  // fast range but memory
        apply(32'hFF30_0000, 0, 2, 1, 0, 1, 1, 1, "R6");
        apply(32'hFF30_0FFC, 0, 2, 1, 0, 1, 1, 1, "R6");
        apply(32'hFF30_1000, 0, 2, 1, 0, 1, 1, 1, "R7");
        apply(32'hFF30_1FFC, 1, 2, 1, 0, 1, 1, 1, "R7");
        apply(32'hFF30_2000, 0, 2, 1, 0, 1, 1, 1, "R7");
        apply(32'hFF3F_FFFC, 1, 2, 1, 0, 0, 0, 1, "R6");
        apply(32'hFF30_0004, 0, 1, 1, 0, 1, 1, 1, "R8");
        apply(32'hFF30_1004, 1, 0, 1, 0, 1, 1, 1, "R8");
        apply(32'hFF30_0002, 0, 2, 1, 0, 1, 1, 1, "R8");
        apply(32'hFF30_0008, 0, 3, 1, 0, 1, 1, 1, "R8");

        for (int i = 0; i < 600; i++) begin
            logic [31:0] a;
            int unsigned k;
            k = $urandom % 6;
            case (k)
                0: a = $urandom;
                1: a = 32'hFF20_0000 | ($urandom & 32'h000F_FFFF);
                2: a = 32'hFF30_0000 | ($urandom & 32'h000F_FFFF);
                3: a = 32'hFF30_1000 | ($urandom & 32'h0000_0FFF);
                4: a = 32'hFF20_0000 | ($urandom & 32'h0000_001F);
                default: a = (($urandom & 1) != 0 ? 32'hFF1F_FFF0 : 32'hFF3F_FFF0)
                             + ($urandom & 32'h1F);
            endcase
            apply(a, 1'($urandom), 2'($urandom), ($urandom % 4) != 0, ($urandom % 4) == 0,
                  ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 8) != 0, "");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule